// File: doc/BRIEF.md
# Elastic Refresh Scheduler

This block decides when one DRAM rank receives its refresh commands. It does not insist on one refresh per interval. It keeps a budget of eight refreshes for each window of eight refresh intervals, and it spends that budget whenever the request queues have been quiet for long enough. Refreshes can therefore move earlier or later within the window, into gaps in traffic. As the window nears its end, any part of the budget still unspent becomes urgent. The block then raises its request whether the queues are idle or not, and the memory controller is expected to let it override normal traffic.

All timing counts one unit per cycle in which `tick` is high. This covers the refresh interval, the window and the refresh completion time. The controller drives `tick` at whatever rate makes the parameters match the real nanosecond values. The idle filter counts plain clock cycles of `queues_idle`. A refresh is issued on a cycle in which `ref_req` and `ref_ack` are both high. From the next cycle, `rank_busy` holds the rank off for the refresh completion time. No new refresh is requested while the rank is busy.

Parameters: `TREFI_TICKS` (interval length, default 780), `TRFC_TICKS` (completion time, default 35, must be at least `REFS_PER_WINDOW`), `REFS_PER_WINDOW` (default 8) and `IDLE_W` (width of the idle threshold).

Top module: `refresh_scheduler`

## Requirements
- R1: After reset `ref_req`, `ref_urgent` and `rank_busy` are low, and the full budget of `REFS_PER_WINDOW` refreshes is available in the first window.
- R2: If the refresh is not urgent, `ref_req` rises only once `queues_idle` has been high for `idle_limit` consecutive clock cycles before the current one and is still high (a limit of 0 means at once). Any low cycle restarts the count.
- R3: A raised `ref_req` stays high until `ref_ack` is seen while its cause persists. A refresh counts as issued only on a cycle with both high.
- R4: After an issued refresh, `rank_busy` is high starting the next cycle for exactly `TRFC_TICKS` tick cycles, and `ref_req` is low whenever `rank_busy` is high.
- R5: The interval, window and busy timers advance only in cycles with `tick` high. With `tick` high on alternate cycles, a refresh keeps the rank busy for twice as many clock cycles.
- R6: A window spans `REFS_PER_WINDOW*TREFI_TICKS` ticks from reset. No more than `REFS_PER_WINDOW` refreshes are issued in one window, even under continuous idleness, and the budget refills at each window boundary.
- R7: `ref_urgent` is high exactly when budget remains and the ticks left in the window are at most (remaining budget + 1) * `TRFC_TICKS`. Ticks left means window length minus 1 minus ticks elapsed in the window.
- R8: While `ref_urgent` is high and the rank is not busy, `ref_req` is high whatever `queues_idle` is.
- R9: With a controller that accepts urgent requests at once and `tick` high every cycle, every budgeted refresh is issued before its window ends. This holds even when the queues never go idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Timing unit enable; all refresh timers advance on it |
| queues_idle | input | 1 | High when the request queues for the rank are empty |
| idle_limit | input | IDLE_W | Consecutive idle cycles needed before an opportunistic refresh |
| ref_ack | input | 1 | Controller accepts the refresh request this cycle |
| ref_req | output | 1 | Refresh command request |
| ref_urgent | output | 1 | Remaining refreshes must be issued now, overriding traffic |
| rank_busy | output | 1 | Rank is in refresh completion time; no command may target it |

## Verification
The assertions check several relations on every cycle. No request is made while the rank is busy. An accepted refresh is followed by a busy rank. The busy period never ends on a cycle without a tick. A request always has idleness or urgency behind it, and urgency always produces a request on a free rank. The per-window cap is also checked every cycle, with a window counter of the checker's own. Only the bench's scenarios can show the exact cycles involved: when the idle filter first lets a request through, and when urgency starts relative to the window end. They also show that forced refreshes all land before the boundary, that an unaccepted request waits, and that a gated tick stretches the busy time.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_IDLE   = 2'd1,
    CAUSE_FORCED = 2'd2
  } ref_cause_e;

  function automatic int unsigned window_ticks(input int unsigned trefi,
                                               input int unsigned nref);
    return trefi * nref;
  endfunction

endpackage

// File: rtl/refsch_window_timer.sv
module refsch_window_timer #(
  parameter int unsigned TREFI_TICKS     = 780,
  parameter int unsigned REFS_PER_WINDOW = 8,
  localparam int unsigned WIN_TICKS      = refsch_pkg::window_ticks(TREFI_TICKS, REFS_PER_WINDOW),
  localparam int unsigned WLW            = $clog2(WIN_TICKS),
  localparam int unsigned IVW            = $clog2(TREFI_TICKS),
  localparam int unsigned SLW            = $clog2(REFS_PER_WINDOW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  output logic [WLW-1:0] ticks_left,
  output logic           win_wrap
);

  localparam logic [IVW-1:0] IVL_LAST  = IVW'(TREFI_TICKS - 1);
  localparam logic [SLW-1:0] SLOT_LAST = SLW'(REFS_PER_WINDOW - 1);

  logic [IVW-1:0] ivl_q, ivl_d;
  logic [SLW-1:0] slot_q, slot_d;
  logic           ivl_end;

  // count-down interval and slot counters
  always_comb begin
    ivl_end  = (ivl_q == '0);
    win_wrap = tick && ivl_end && (slot_q == '0);
    ivl_d    = ivl_q;
    slot_d   = slot_q;
    if (tick) begin
      if (ivl_end) begin
        ivl_d  = IVL_LAST;
        slot_d = (slot_q == '0) ? SLOT_LAST : slot_q - SLW'(1);
      end else begin
        ivl_d = ivl_q - IVW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= IVL_LAST;
      slot_q <= SLOT_LAST;
    end else if (tick) begin
      ivl_q  <= ivl_d;
      slot_q <= slot_d;
    end
  end

  assign ticks_left = WLW'(slot_q) * WLW'(TREFI_TICKS) + WLW'(ivl_q);

endmodule

// File: rtl/refsch_idle_filter.sv
module refsch_idle_filter #(
  parameter int unsigned IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              queues_idle,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              idle_ok
);

  logic [IDLE_W-1:0] run_q, run_d;

  always_comb begin
    if (!queues_idle)
      run_d = '0;
    else if (&run_q)
      run_d = run_q;
    else
      run_d = run_q + IDLE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else
      run_q <= run_d;
  end

  assign idle_ok = queues_idle && (run_q >= idle_limit);

endmodule

// File: rtl/refsch_busy_timer.sv
module refsch_busy_timer #(
  parameter int unsigned TRFC_TICKS = 35,
  localparam int unsigned BSW       = $clog2(TRFC_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic busy
);

  logic [BSW-1:0] cnt_q, cnt_d;
  logic           cnt_en;

  always_comb begin
    cnt_en = start || (tick && (cnt_q != '0));
    if (start)
      cnt_d = BSW'(TRFC_TICKS);
    else
      cnt_d = cnt_q - BSW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
  parameter int unsigned TREFI_TICKS     = 780,
  parameter int unsigned TRFC_TICKS      = 35,
  parameter int unsigned REFS_PER_WINDOW = 8,
  parameter int unsigned IDLE_W          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              queues_idle,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              ref_ack,
  output logic              ref_req,
  output logic              ref_urgent,
  output logic              rank_busy
);

  import refsch_pkg::*;

  localparam int unsigned WIN_TICKS = window_ticks(TREFI_TICKS, REFS_PER_WINDOW);
  localparam int unsigned WLW       = $clog2(WIN_TICKS);
  localparam int unsigned BW        = $clog2(REFS_PER_WINDOW + 1);
  localparam int unsigned CW        = $clog2(WIN_TICKS + (REFS_PER_WINDOW + 1) * TRFC_TICKS + 1);
  localparam logic [BW-1:0] FULL_BUDGET = BW'(REFS_PER_WINDOW);

  logic [WLW-1:0] ticks_left;
  logic           win_wrap;
  logic           idle_ok;
  logic           grant;
  logic [BW-1:0]  budget_q, budget_d;
  logic           budget_en;
  logic [CW-1:0]  urgent_thr;
  ref_cause_e     cause;

  refsch_window_timer #(
    .TREFI_TICKS    (TREFI_TICKS),
    .REFS_PER_WINDOW(REFS_PER_WINDOW)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ticks_left(ticks_left),
    .win_wrap  (win_wrap)
  );

  refsch_idle_filter #(
    .IDLE_W(IDLE_W)
  ) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .queues_idle(queues_idle),
    .idle_limit (idle_limit),
    .idle_ok    (idle_ok)
  );

  refsch_busy_timer #(
    .TRFC_TICKS(TRFC_TICKS)
  ) u_busy (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .start(grant),
    .busy (rank_busy)
  );

  // urgency: the remaining budget plus one refresh of slack must fit in the window
  always_comb begin
    urgent_thr = (CW'(budget_q) + CW'(1)) * CW'(TRFC_TICKS);
    ref_urgent = (budget_q != '0) && (CW'(ticks_left) <= urgent_thr);
  end

  always_comb begin
    if (rank_busy || (budget_q == '0))
      cause = CAUSE_NONE;
    else if (ref_urgent)
      cause = CAUSE_FORCED;
    else if (idle_ok)
      cause = CAUSE_IDLE;
    else
      cause = CAUSE_NONE;
  end

  assign ref_req = (cause != CAUSE_NONE);
  assign grant   = ref_req && ref_ack;

  // budget: refill at the window boundary, spend one per issued refresh
  always_comb begin
    budget_en = win_wrap || grant;
    if (win_wrap)
      budget_d = FULL_BUDGET;
    else
      budget_d = budget_q - BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      budget_q <= FULL_BUDGET;
    else if (budget_en)
      budget_q <= budget_d;
  end

endmodule

// File: rtl/refresh_scheduler_checker.sv
module refresh_scheduler_checker #(
  parameter int unsigned TREFI_TICKS     = 780,
  parameter int unsigned TRFC_TICKS      = 35,
  parameter int unsigned REFS_PER_WINDOW = 8,
  parameter int unsigned IDLE_W          = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              queues_idle,
  input logic [IDLE_W-1:0] idle_limit,
  input logic              ref_ack,
  input logic              ref_req,
  input logic              ref_urgent,
  input logic              rank_busy
);

  localparam int unsigned WIN_TICKS = TREFI_TICKS * REFS_PER_WINDOW;
  localparam int unsigned PW        = $clog2(WIN_TICKS);
  localparam int unsigned GW        = $clog2(REFS_PER_WINDOW + 1);

  logic [PW-1:0] pos_q;
  logic [GW-1:0] gcnt_q;
  logic          wrap;
  logic          grant;
  logic          limit_unused;

  assign wrap         = tick && (pos_q == PW'(WIN_TICKS - 1));
  assign grant        = ref_req && ref_ack;
  assign limit_unused = ^idle_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      gcnt_q <= '0;
    end else begin
      if (tick)
        pos_q <= wrap ? '0 : pos_q + PW'(1);
      if (wrap)
        gcnt_q <= '0;
      else if (grant)
        gcnt_q <= gcnt_q + GW'(1);
    end
  end

  assert_busy_blocks_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rank_busy |-> !ref_req);

  assert_grant_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_ack) |=> rank_busy);

  assert_busy_holds_without_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rank_busy && !tick) |=> rank_busy);

  assert_busy_ends_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rank_busy) |-> $past(tick));

  assert_req_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (queues_idle || ref_urgent));

  assert_urgent_overrides_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent && !rank_busy) |-> ref_req);

  assert_window_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (gcnt_q < GW'(REFS_PER_WINDOW)));

endmodule

bind refresh_scheduler refresh_scheduler_checker #(
  .TREFI_TICKS    (TREFI_TICKS),
  .TRFC_TICKS     (TRFC_TICKS),
  .REFS_PER_WINDOW(REFS_PER_WINDOW),
  .IDLE_W         (IDLE_W)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .queues_idle(queues_idle),
  .idle_limit (idle_limit),
  .ref_ack    (ref_ack),
  .ref_req    (ref_req),
  .ref_urgent (ref_urgent),
  .rank_busy  (rank_busy)
);

// File: tb/refresh_scheduler_bench.sv
module refresh_scheduler_bench;

  localparam int TREFI = 40;
  localparam int TRFC  = 10;
  localparam int NREF  = 8;
  localparam int IW    = 8;

  logic          clk;
  logic          rst_n;
  logic          tick;
  logic          queues_idle;
  logic [IW-1:0] idle_limit;
  logic          ref_ack;
  logic          ref_req;
  logic          ref_urgent;
  logic          rank_busy;

  int checks;
  int errors;
  int tk;

  typedef struct {
    int t;
    bit urg;
  } exp_t;
  exp_t sbq[$];

  refresh_scheduler #(
    .TREFI_TICKS    (TREFI),
    .TRFC_TICKS     (TRFC),
    .REFS_PER_WINDOW(NREF),
    .IDLE_W         (IW)
  ) u_refresh_scheduler (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .queues_idle(queues_idle),
    .idle_limit (idle_limit),
    .ref_ack    (ref_ack),
    .ref_req    (ref_req),
    .ref_urgent (ref_urgent),
    .rank_busy  (rank_busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // tick counter of the bench: ticks elapsed since reset release
  always @(posedge clk) begin
    if (!rst_n) tk <= 0;
    else if (tick) tk <= tk + 1;
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (tick %0d)", rq, what, act, exp, tk);
    end
  endtask

  task automatic push_exp(input int t, input bit urg);
    exp_t e;
    e.t   = t;
    e.urg = urg;
    sbq.push_back(e);
  endtask

  task automatic wait_tk(input int n);
    while (tk < n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: every issued refresh is popped and compared against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && ref_req && ref_ack) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R6", "unexpected refresh issued", tk, -1);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(e.t == tk, "R9", "refresh issue tick", tk, e.t);
          check(e.urg == ref_urgent, "R7", "urgent flag at issue", int'(ref_urgent), int'(e.urg));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    checks      = 0;
    errors      = 0;
    rst_n       = 1'b0;
    tick        = 1'b1;
    queues_idle = 1'b0;
    idle_limit  = IW'(3);
    ref_ack     = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(ref_req == 1'b0, "R1", "ref_req after reset", int'(ref_req), 0);
    check(ref_urgent == 1'b0, "R1", "ref_urgent after reset", int'(ref_urgent), 0);
    check(rank_busy == 1'b0, "R1", "rank_busy after reset", int'(rank_busy), 0);

    // window 0: idle burst spends the whole budget early (R2, R4, R6)
    wait_tk(10);
    queues_idle = 1'b1;
    for (int j = 0; j < NREF; j++) push_exp(13 + 11 * j, 1'b0);
    wait_tk(12);
    #1 check(ref_req == 1'b0, "R2", "request before idle limit", int'(ref_req), 0);
    wait_tk(13);
    #1 check(ref_req == 1'b1, "R2", "request at idle limit", int'(ref_req), 1);
    wait_tk(14);
    #1 check(rank_busy == 1'b1, "R4", "busy first cycle after issue", int'(rank_busy), 1);
    wait_tk(23);
    #1 check(rank_busy == 1'b1, "R4", "busy last tick of completion time", int'(rank_busy), 1);
    wait_tk(24);
    #1 check(rank_busy == 1'b0, "R4", "busy released after completion time", int'(rank_busy), 0);
    wait_tk(150);
    #1 check(ref_req == 1'b0, "R6", "no request once budget spent", int'(ref_req), 0);
    check(sbq.size() == 0, "R6", "burst refreshes outstanding", sbq.size(), 0);
    queues_idle = 1'b0;

    // window 1: short idle glitch, then forced refreshes (R2, R7, R8, R9)
    for (int j = 0; j < NREF; j++) push_exp(549 + 11 * j, 1'b1);
    wait_tk(400);
    queues_idle = 1'b1;
    wait_tk(401);
    #1 check(ref_req == 1'b0, "R2", "short idle run gives no request", int'(ref_req), 0);
    wait_tk(402);
    queues_idle = 1'b0;
    wait_tk(548);
    #1 check(ref_urgent == 1'b0, "R7", "urgent just before threshold", int'(ref_urgent), 0);
    wait_tk(549);
    #1 check(ref_urgent == 1'b1, "R7", "urgent at threshold", int'(ref_urgent), 1);
    check(ref_req == 1'b1, "R8", "forced request with busy queues", int'(ref_req), 1);
    wait_tk(630);
    #1 check(ref_urgent == 1'b0, "R7", "urgent clears once budget spent", int'(ref_urgent), 0);
    wait_tk(640);
    check(sbq.size() == 0, "R9", "forced refreshes outstanding at window end", sbq.size(), 0);

    // window 2: gated tick stretches the completion time (R5), refill then force (R6)
    wait_tk(660);
    tick        = 1'b0;
    queues_idle = 1'b1;
    idle_limit  = IW'(0);
    push_exp(660, 1'b0);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      tick = (k % 2 == 1);
      if (k == 1) queues_idle = 1'b0;
      if (k == 19) begin
        #1 check(rank_busy == 1'b1, "R5", "busy held with half-rate tick", int'(rank_busy), 1);
      end
      if (k == 20) begin
        #1 check(rank_busy == 1'b0, "R5", "busy ends after ten ticks", int'(rank_busy), 0);
      end
    end
    @(negedge clk);
    tick = 1'b1;
    for (int j = 0; j < NREF - 1; j++) push_exp(879 + 11 * j, 1'b1);
    wait_tk(879);
    #1 check(ref_urgent == 1'b1, "R7", "urgent threshold with budget seven", int'(ref_urgent), 1);
    wait_tk(960);
    check(sbq.size() == 0, "R6", "refreshes outstanding at second boundary", sbq.size(), 0);

    // window 3: request waits for acceptance (R3)
    wait_tk(970);
    idle_limit  = IW'(2);
    queues_idle = 1'b1;
    ref_ack     = 1'b0;
    wait_tk(976);
    #1 check(ref_req == 1'b1, "R3", "request held without acceptance", int'(ref_req), 1);
    check(rank_busy == 1'b0, "R3", "no busy without acceptance", int'(rank_busy), 0);
    wait_tk(977);
    ref_ack = 1'b1;
    push_exp(977, 1'b0);
    wait_tk(978);
    queues_idle = 1'b0;
    ref_ack     = 1'b0;
    #1 check(rank_busy == 1'b1, "R3", "busy after accepted request", int'(rank_busy), 1);
    wait_tk(990);
    check(sbq.size() == 0, "R3", "accepted refresh missing", sbq.size(), 0);
    finish_run();
  end

endmodule